// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives a host a byte-wide path into a chip's configuration space through two neighbouring I/O addresses. The lower address is the index port and the one above it is the data port. The space is closed after reset. It opens only after a two-byte unlock key arrives at the index port. While it is open, a write to the index port picks a register, and a read or write at the data port reaches that register. A separate lock key closes the space again.

Indices below 0x30 are global. They hold the device-select register and the read-only identity bytes. Indices from 0x30 upward are banked by the device-select value. In each bank the block keeps an enable bit and a 16-bit base address of its own. Every other banked index is passed on to the logical devices over a simple register bus: device number, index, write data, a one-cycle write strobe, and a read-data return. Reads are combinational, so the read data is valid in the same cycle as the read strobe.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the port is locked, the index latch holds 0x00, every device enable is 0 and every device base address is 0x0000.
- R2: The port opens only after two index-port writes of 0x87 in a row. Any other index-port write while the port is not open restarts the key sequence, so the writes 0x87, 0x11, 0x87 leave the port closed.
- R3: While the port is locked, reads of the index port and the data port return 0xFF. Data-port writes change no register and never raise the register-bus write strobe.
- R4: While the port is open, an index-port write of 0xAA locks it. Any other index-port write value, 0x87 included, is loaded into the index latch and can be read back at the index port. The latch keeps its value across lock and unlock.
- R5: Index 0x20 reads as the device ID high byte, 0x21 as the device ID low byte, 0x22 as the revision byte, 0x23 as the manufacturer ID high byte and 0x24 as the manufacturer ID low byte. Writes to these indices are ignored.
- R6: Index 0x07 is an 8-bit device-select register that can be read and written. Its value picks the bank used by every index of 0x30 and above.
- R7: In the selected bank, bit 0 of index 0x30 is the device enable. It drives ld_en_o at the selected device's position and reads back with bits 7:1 as zero.
- R8: In the selected bank, index 0x60 holds the high byte and index 0x61 holds the low byte of the device's base address. The address appears on ld_base_o, bits [16n+15:16n] for device n.
- R9: A data-port write to any other banked index raises ld_we_o for that single cycle, together with ld_sel_o, ld_idx_o and ld_wdata_o. A data-port read of such an index returns ld_rdata_i. Writes to 0x30, 0x60 and 0x61 never raise ld_we_o.
- R10: When the device-select value is NUM_LD or more, banked reads return 0x00 and banked writes are ignored, with no ld_we_o pulse.
- R11: Global indices other than 0x07 and 0x20 to 0x24 read as 0x00 and ignore writes.
- R12: The index port sits at 0x2E (0x4E when ALT_BASE is 1) and the data port one above it. Accesses to any other address have no effect, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | I/O address of the access |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, valid while io_rd_i is high |
| ld_sel_o | output | LD_W | Selected logical device number |
| ld_idx_o | output | 8 | Current register index |
| ld_wdata_o | output | 8 | Write data passed to the logical devices |
| ld_we_o | output | 1 | Write strobe for a forwarded banked register |
| ld_rdata_i | input | 8 | Read data from the selected logical device |
| ld_en_o | output | NUM_LD | Enable bit of each logical device |
| ld_base_o | output | 16*NUM_LD | Base address of each logical device |

## Verification
The assertions take for granted that the host never raises the read and write strobes in the same cycle, and that each write strobe lasts one cycle per access. The read-data checks also assume that ld_rdata_i is driven whenever a forwarded index is read. The bench drives every access from one task per access type. Each task releases the strobes at the next falling edge. The bench models the device read bus as a pure function of ld_sel_o and ld_idx_o, so it always has a defined value.

// File: rtl/cfg_port_pkg.sv
`timescale 1ns/1ps
package cfg_port_pkg;
  typedef enum logic [1:0] {ST_LOCKED, ST_KEY1, ST_OPEN} unlock_st_e;

  localparam logic [7:0] KEY_UNLOCK   = 8'h87;
  localparam logic [7:0] KEY_LOCK     = 8'hAA;
  localparam logic [7:0] IDX_LDSEL    = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO = 8'h21;
  localparam logic [7:0] IDX_REV      = 8'h22;
  localparam logic [7:0] IDX_MFR_HI   = 8'h23;
  localparam logic [7:0] IDX_MFR_LO   = 8'h24;
  localparam logic [7:0] IDX_BANK_LO  = 8'h30;
  localparam logic [7:0] IDX_LD_EN    = 8'h30;
  localparam logic [7:0] IDX_BASE_HI  = 8'h60;
  localparam logic [7:0] IDX_BASE_LO  = 8'h61;
endpackage

// File: rtl/cfg_unlock_fsm.sv
`timescale 1ns/1ps
module cfg_unlock_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic [7:0] key_i,
  output logic       open_o,
  output logic       idx_ld_o
);
  unlock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOCKED: if (key_wr_i) st_d = (key_i == KEY_UNLOCK) ? ST_KEY1 : ST_LOCKED;
      ST_KEY1:   if (key_wr_i) st_d = (key_i == KEY_UNLOCK) ? ST_OPEN : ST_LOCKED;
      ST_OPEN:   if (key_wr_i && key_i == KEY_LOCK) st_d = ST_LOCKED;
      default:   st_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_LOCKED;
    else         st_q <= st_d;
  end

  assign open_o   = (st_q == ST_OPEN);
  assign idx_ld_o = key_wr_i && open_o && (key_i != KEY_LOCK);
endmodule

// File: rtl/cfg_id_regs.sv
`timescale 1ns/1ps
module cfg_id_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'h5A31,
  parameter logic [7:0]  REV_ID = 8'h04,
  parameter logic [15:0] MFR_ID = 16'h3C29
) (
  input  logic [7:0] idx_i,
  output logic       hit_o,
  output logic [7:0] data_o
);
  always_comb begin
    hit_o  = 1'b1;
    data_o = 8'h00;
    unique case (idx_i)
      IDX_DEVID_HI: data_o = DEV_ID[15:8];
      IDX_DEVID_LO: data_o = DEV_ID[7:0];
      IDX_REV:      data_o = REV_ID;
      IDX_MFR_HI:   data_o = MFR_ID[15:8];
      IDX_MFR_LO:   data_o = MFR_ID[7:0];
      default:      hit_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_ld_bank.sv
`timescale 1ns/1ps
module cfg_ld_bank
  import cfg_port_pkg::*;
#(
  parameter int NUM_LD = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [7:0]             sel_i,
  input  logic [7:0]             idx_i,
  input  logic [7:0]             wdata_i,
  output logic                   hit_o,
  output logic [7:0]             rdata_o,
  output logic [NUM_LD-1:0]      en_o,
  output logic [16*NUM_LD-1:0]   base_o
);
  logic [15:0] base_q [NUM_LD];
  logic [NUM_LD-1:0] en_q;

  assign hit_o = (idx_i == IDX_LD_EN) || (idx_i == IDX_BASE_HI) || (idx_i == IDX_BASE_LO);

  for (genvar g = 0; g < NUM_LD; g++) begin : g_ld
    logic wr_me;
    assign wr_me = wr_i && (sel_i == 8'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[g]   <= 1'b0;
        base_q[g] <= '0;
      end else if (wr_me) begin
        if (idx_i == IDX_LD_EN)   en_q[g]         <= wdata_i[0];
        if (idx_i == IDX_BASE_HI) base_q[g][15:8] <= wdata_i;
        if (idx_i == IDX_BASE_LO) base_q[g][7:0]  <= wdata_i;
      end
    end

    assign base_o[16*g +: 16] = base_q[g];
  end

  assign en_o = en_q;

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NUM_LD; i++) begin
      if (sel_i == 8'(i)) begin
        if (idx_i == IDX_LD_EN)   rdata_o = {7'b0, en_q[i]};
        if (idx_i == IDX_BASE_HI) rdata_o = base_q[i][15:8];
        if (idx_i == IDX_BASE_LO) rdata_o = base_q[i][7:0];
      end
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
`timescale 1ns/1ps
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          NUM_LD   = 8,
  parameter bit          ALT_BASE = 1'b0,
  parameter logic [15:0] DEV_ID   = 16'h5A31,
  parameter logic [7:0]  REV_ID   = 8'h04,
  parameter logic [15:0] MFR_ID   = 16'h3C29,
  localparam int         LD_W     = (NUM_LD > 1) ? $clog2(NUM_LD) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     io_addr_i,
  input  logic                  io_wr_i,
  input  logic                  io_rd_i,
  input  logic [7:0]            io_wdata_i,
  output logic [7:0]            io_rdata_o,
  output logic [LD_W-1:0]       ld_sel_o,
  output logic [7:0]            ld_idx_o,
  output logic [7:0]            ld_wdata_o,
  output logic                  ld_we_o,
  input  logic [7:0]            ld_rdata_i,
  output logic [NUM_LD-1:0]     ld_en_o,
  output logic [16*NUM_LD-1:0]  ld_base_o
);
  localparam logic [ADDR_W-1:0] BASE_ADDR = ALT_BASE ? ADDR_W'(16'h004E) : ADDR_W'(16'h002E);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  logic       hit_idx, hit_dat, idx_wr, dat_wr;
  logic       cfg_open, idx_ld;
  logic [7:0] idx_q, sel_q;
  logic       sel_ok, banked, bank_hit, id_hit;
  logic [7:0] bank_rd, id_rd, dat_rd;

  assign hit_idx = (io_addr_i == BASE_ADDR);
  assign hit_dat = (io_addr_i == DATA_ADDR);
  assign idx_wr  = io_wr_i && hit_idx;
  assign dat_wr  = io_wr_i && hit_dat && cfg_open;

  cfg_unlock_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (idx_wr),
    .key_i    (io_wdata_i),
    .open_o   (cfg_open),
    .idx_ld_o (idx_ld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h00;
      sel_q <= 8'h00;
    end else begin
      if (idx_ld) idx_q <= io_wdata_i;
      if (dat_wr && idx_q == IDX_LDSEL) sel_q <= io_wdata_i;
    end
  end

  assign sel_ok = ({1'b0, sel_q} < 9'(NUM_LD));
  assign banked = (idx_q >= IDX_BANK_LO);

  cfg_ld_bank #(.NUM_LD(NUM_LD)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (dat_wr && banked && sel_ok),
    .sel_i   (sel_q),
    .idx_i   (idx_q),
    .wdata_i (io_wdata_i),
    .hit_o   (bank_hit),
    .rdata_o (bank_rd),
    .en_o    (ld_en_o),
    .base_o  (ld_base_o)
  );

  cfg_id_regs #(.DEV_ID(DEV_ID), .REV_ID(REV_ID), .MFR_ID(MFR_ID)) u_id (
    .idx_i  (idx_q),
    .hit_o  (id_hit),
    .data_o (id_rd)
  );

  // forwarded banked access to the logical devices
  assign ld_sel_o   = sel_q[LD_W-1:0];
  assign ld_idx_o   = idx_q;
  assign ld_wdata_o = io_wdata_i;
  assign ld_we_o    = dat_wr && banked && sel_ok && !bank_hit;

  always_comb begin
    if (banked)                  dat_rd = !sel_ok ? 8'h00 : (bank_hit ? bank_rd : ld_rdata_i);
    else if (idx_q == IDX_LDSEL) dat_rd = sel_q;
    else if (id_hit)             dat_rd = id_rd;
    else                         dat_rd = 8'h00;
  end

  always_comb begin
    io_rdata_o = 8'hFF;
    if (io_rd_i && cfg_open) begin
      if (hit_idx)      io_rdata_o = idx_q;
      else if (hit_dat) io_rdata_o = dat_rd;
    end
  end
endmodule

// File: rtl/cfg_index_port_chk.sv
`timescale 1ns/1ps
module cfg_index_port_chk #(
  parameter int          ADDR_W = 16,
  parameter int          NUM_LD = 8,
  parameter logic [15:0] BASE   = 16'h002E
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              ld_we_o,
  input logic [NUM_LD-1:0] ld_en_o,
  input logic              cfg_open,
  input logic [7:0]        idx_q
);
  logic key_wr;
  assign key_wr = io_wr_i && (io_addr_i == ADDR_W'(BASE));

  AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_open) |-> $past(key_wr && io_wdata_i == 8'h87)); // R2
  AST_LOCK_KEY_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open && key_wr && io_wdata_i == 8'hAA) |=> !cfg_open); // R4
  AST_LOCKED_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open |-> !ld_we_o); // R3
  AST_LOCKED_READ_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open && io_rd_i) |-> io_rdata_o == 8'hFF); // R3
  AST_LOCKED_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open |=> $stable(ld_en_o)); // R3
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_open && key_wr) |=> $stable(idx_q)); // R4
  AST_FWD_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_o |-> (io_wr_i && io_addr_i == ADDR_W'(BASE) + ADDR_W'(1))); // R9
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .ADDR_W (ADDR_W),
  .NUM_LD (NUM_LD),
  .BASE   (16'(BASE_ADDR))
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_addr_i  (io_addr_i),
  .io_wr_i    (io_wr_i),
  .io_rd_i    (io_rd_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .ld_we_o    (ld_we_o),
  .ld_en_o    (ld_en_o),
  .cfg_open   (cfg_open),
  .idx_q      (idx_q)
);

// File: tb/cfg_index_port_bench.sv
`timescale 1ns/1ps
module cfg_index_port_bench;
  localparam int NUM_LD = 8;
  localparam logic [15:0] BI = 16'h002E;
  localparam logic [15:0] BD = 16'h002F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [2:0] ld_sel;
  logic [7:0] ld_idx, ld_wdata, ld_rdata;
  logic ld_we;
  logic [NUM_LD-1:0] ld_en;
  logic [16*NUM_LD-1:0] ld_base;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  // device-side read model
  assign ld_rdata = {ld_sel, ld_idx[4:0]} ^ 8'hC3;

  cfg_index_port u_cfg_index_port (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .ld_sel_o(ld_sel), .ld_idx_o(ld_idx),
    .ld_wdata_o(ld_wdata), .ld_we_o(ld_we), .ld_rdata_i(ld_rdata), .ld_en_o(ld_en),
    .ld_base_o(ld_base)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); io_addr = a; io_wr = 1'b0; io_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic sel_idx(input logic [7:0] i);
    wr(BI, i);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // monitor: compares read data one ns after the edge
  initial forever begin
    @(posedge clk); #1;
    if (io_rd) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else chk(tag_q.pop_front(), {24'b0, io_rdata}, {24'b0, exp_q.pop_front()});
    end
  end

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk("R1 ld_en reset", 32'(ld_en), 0);
    chk("R1 ld_base reset", 32'(ld_base[31:0] | ld_base[127:96]), 0);
    chk("R1 ld_we reset", 32'(ld_we), 0);
    rd(BD, 8'hFF, "R1 locked data read");
    rd(BI, 8'hFF, "R3 locked index read");

    wr(BI, 8'h87); wr(BI, 8'h11); wr(BI, 8'h87);
    rd(BI, 8'hFF, "R2 broken key stays locked");
    wr(BI, 8'h87);
    rd(BI, 8'h00, "R2 open after two keys / R1 index reset");

    sel_idx(8'h20); rd(BI, 8'h20, "R4 index latch readback");
    rd(BD, 8'h5A, "R5 devid hi");
    sel_idx(8'h21); rd(BD, 8'h31, "R5 devid lo");
    sel_idx(8'h22); wr(BD, 8'h55); rd(BD, 8'h04, "R5 revision ignores write");
    sel_idx(8'h23); rd(BD, 8'h3C, "R5 mfr hi");
    sel_idx(8'h24); rd(BD, 8'h29, "R5 mfr lo");

    sel_idx(8'h10); wr(BD, 8'h77); rd(BD, 8'h00, "R11 unmapped global");

    sel_idx(8'h07); wr(BD, 8'h02); rd(BD, 8'h02, "R6 select readback");
    sel_idx(8'h30); wr(BD, 8'hFF); idle();
    chk("R7 enable dev2", 32'(ld_en), 32'h04);
    rd(BD, 8'h01, "R7 enable readback");
    sel_idx(8'h60); wr(BD, 8'h12); sel_idx(8'h61); wr(BD, 8'h34); idle();
    chk("R8 base dev2", 32'(ld_base[47:32]), 32'h1234);
    rd(BD, 8'h34, "R8 base lo readback");
    sel_idx(8'h60); rd(BD, 8'h12, "R8 base hi readback");

    sel_idx(8'h07); wr(BD, 8'h05);
    sel_idx(8'h30); wr(BD, 8'h01); idle();
    chk("R6 bank switch enable", 32'(ld_en), 32'h24);
    sel_idx(8'h60); rd(BD, 8'h00, "R6 dev5 base separate");

    sel_idx(8'hF5); wr(BD, 8'h40); #1;
    chk("R9 we pulse", 32'(ld_we), 1);
    chk("R9 sel", 32'(ld_sel), 5);
    chk("R9 idx", 32'(ld_idx), 32'hF5);
    chk("R9 wdata", 32'(ld_wdata), 32'h40);
    idle(); #1;
    chk("R9 we single cycle", 32'(ld_we), 0);
    rd(BD, {3'd5, 5'h15} ^ 8'hC3, "R9 forwarded read");
    sel_idx(8'h30); wr(BD, 8'h01); #1;
    chk("R9 local reg no we", 32'(ld_we), 0);

    sel_idx(8'h07); wr(BD, 8'h09);
    sel_idx(8'h30); rd(BD, 8'h00, "R10 bad select read");
    wr(BD, 8'h00); idle();
    chk("R10 bad select write ignored", 32'(ld_en), 32'h24);
    sel_idx(8'hF0); wr(BD, 8'h11); #1;
    chk("R10 bad select no we", 32'(ld_we), 0);

    sel_idx(8'h07); wr(BD, 8'h02); sel_idx(8'h30);
    wr(BI, 8'hAA);
    rd(BD, 8'hFF, "R4 lock key closes");
    wr(BD, 8'h00); #1;
    chk("R3 locked no we", 32'(ld_we), 0);
    idle();
    chk("R3 locked write ignored", 32'(ld_en), 32'h24);

    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
    rd(BI, 8'hFF, "R12 key at other address ignored");
    wr(BI, 8'h87); wr(BI, 8'h87);
    rd(BI, 8'h30, "R4 latch held across lock");
    rd(BD, 8'h01, "R3 enable survived locked write");
    wr(16'h004F, 8'h00); idle();
    chk("R12 foreign data write ignored", 32'(ld_en), 32'h24);
    rd(16'h004F, 8'hFF, "R12 foreign read");
    wr(BI, 8'h87); rd(BI, 8'h87, "R4 unlock byte as index when open");

    repeat (3) idle();
    chk("scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule